// File: doc/BRIEF.md
# Power-Good and Bus-Good Status Reporter

This block drives the two status flags of a multi-rail regulator. The power-good flag covers the switching core rail together with every linear rail. The bus-good flag covers only the bus rail, which is rail 2. Both flags are registered outputs that a pad stage turns into open-drain signals.

The block takes these inputs:
- the core feedback level as a percentage of the programmed reference, produced by an external converter;
- one under-voltage flag per linear rail, from the analog comparators;
- the soft-start level shared by the core and rail 3, and the rail-2 voltage, both as millivolt codes;
- a strobe that marks each PWM pulse;
- a signal that is high while outputs 1 to 3 are shut down or inhibited.

The core rail is judged against a window with hysteresis. Bus-good is released in step with switching: it rises on the first PWM pulse that arrives after soft-start has passed its threshold. Power-good rises only when the start-up sequence has finished, which is marked by bus-good being high, and when every rail is within its limits.

Top module: `pwr_status_rpt`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pgood` and `bus_good` are both 0.
- R2: A core level below 90 or above 110 (percent of reference, unsigned code in `core_ratio_pct`) makes `pgood` 0 at the next clock edge.
- R3: The core window has 2% hysteresis. Once the core is outside the window, the level must be between 92 and 108 inclusive for it to count as inside again. Once inside, any level from 90 to 110 inclusive keeps it inside.
- R4: If any bit of `lin_uv` is 1, `pgood` is 0 at the next edge. `bus_good` does not depend on `lin_uv`.
- R5: A `rail2_mv` value below 1080 makes `bus_good` 0 at the next edge.
- R6: A `ss_mv` value below 1250 makes `bus_good` 0 at the next edge, and a PWM pulse arriving in that state does not raise it.
- R7: `bus_good` rises only at the edge after a cycle in which `pwm_pulse` is 1, `ss_mv` is at least 1250 and `rail2_mv` is at least 1080.
- R8: `pgood` is 1 only while `bus_good` is 1. It rises together with `bus_good` if the core is inside the window and no `lin_uv` bit is set.
- R9: When `out_inhibit` is 1, both flags are 0 at the next edge.
- R10: Once high, `bus_good` stays high without further pulses for as long as its conditions hold. After it drops, a new PWM pulse is needed to raise it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_ratio_pct | input | RATIO_W | Core feedback as percent of reference |
| lin_uv | input | NUM_LIN | Under-voltage flag per linear rail |
| ss_mv | input | MV_W | Core/rail-3 soft-start level, mV |
| rail2_mv | input | MV_W | Bus rail voltage, mV |
| pwm_pulse | input | 1 | One-cycle strobe per PWM pulse |
| out_inhibit | input | 1 | Outputs 1 to 3 shut down or inhibited |
| pgood | output | 1 | Power-good flag |
| bus_good | output | 1 | Bus-good flag |

## Verification
The core level is swept through the hysteresis band from both sides: 109 and 91 are applied once while inside the window and once while outside. This separates a design with hysteresis from one that uses a single threshold. Soft-start and rail-2 levels are set one code below and exactly at their thresholds, with PWM pulses both present and absent, so the bench can tell a level gate from the pulse gate. Under-voltage flags and the inhibit signal are applied while both flags are high, which shows which flag each one is allowed to affect. Recovery after every drop is then checked to confirm that bus-good waits for a new pulse.

// File: rtl/pwr_status_pkg.sv
package pwr_status_pkg;
  function automatic logic in_band(input int unsigned val,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (val >= lo) && (val <= hi);
  endfunction
endpackage

// File: rtl/core_window.sv
module core_window #(
  parameter int RATIO_W  = 8,
  parameter int LOW_PCT  = 90,
  parameter int HIGH_PCT = 110,
  parameter int HYST_PCT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  output logic               in_win_d,
  output logic               in_win_q
);
  import pwr_status_pkg::*;

  localparam int ENTER_LO = LOW_PCT + HYST_PCT;
  localparam int ENTER_HI = HIGH_PCT - HYST_PCT;

  logic keep_ok, enter_ok;

  always_comb begin
    keep_ok  = in_band(int'(ratio), LOW_PCT, HIGH_PCT);
    enter_ok = in_band(int'(ratio), ENTER_LO, ENTER_HI);
    in_win_d = in_win_q ? keep_ok : enter_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_win_q <= 1'b0;
    else        in_win_q <= in_win_d;
  end

  assert_window_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(ratio) < LOW_PCT) || (int'(ratio) > HIGH_PCT)) |=> !in_win_q);

  assert_window_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_win_q && ((int'(ratio) < ENTER_LO) || (int'(ratio) > ENTER_HI))) |=> !in_win_q);
endmodule

// File: rtl/bus_good_seq.sv
module bus_good_seq #(
  parameter int MV_W        = 12,
  parameter int RAIL2_MIN_MV = 1080,
  parameter int SS_MIN_MV    = 1250
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MV_W-1:0] ss_mv,
  input  logic [MV_W-1:0] rail2_mv,
  input  logic            pwm_pulse,
  input  logic            inhibit,
  output logic            bg_d,
  output logic            bg_q
);
  logic ss_ok, rail2_ok, arm_en;

  always_comb begin
    ss_ok    = int'(ss_mv) >= SS_MIN_MV;
    rail2_ok = int'(rail2_mv) >= RAIL2_MIN_MV;
    arm_en   = !inhibit && ss_ok && rail2_ok;
    bg_d     = arm_en && (bg_q || pwm_pulse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bg_q <= 1'b0;
    else        bg_q <= bg_d;
  end

  assert_rail2_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rail2_mv) < RAIL2_MIN_MV) |=> !bg_q);

  assert_ss_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ss_mv) < SS_MIN_MV) |=> !bg_q);

  assert_rise_on_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_q) |-> $past(pwm_pulse));
endmodule

// File: rtl/pwr_status_rpt.sv
module pwr_status_rpt #(
  parameter int RATIO_W      = 8,
  parameter int MV_W         = 12,
  parameter int NUM_LIN      = 3,
  parameter int LOW_PCT      = 90,
  parameter int HIGH_PCT     = 110,
  parameter int HYST_PCT     = 2,
  parameter int RAIL2_MIN_MV = 1080,
  parameter int SS_MIN_MV    = 1250
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] core_ratio_pct,
  input  logic [NUM_LIN-1:0] lin_uv,
  input  logic [MV_W-1:0]    ss_mv,
  input  logic [MV_W-1:0]    rail2_mv,
  input  logic               pwm_pulse,
  input  logic               out_inhibit,
  output logic               pgood,
  output logic               bus_good
);
  logic win_d, win_q;
  logic bg_d, bg_q;
  logic pg_d, pg_q;
  logic any_uv;

  core_window #(
    .RATIO_W(RATIO_W), .LOW_PCT(LOW_PCT), .HIGH_PCT(HIGH_PCT), .HYST_PCT(HYST_PCT)
  ) u_win (
    .clk(clk), .rst_n(rst_n), .ratio(core_ratio_pct),
    .in_win_d(win_d), .in_win_q(win_q)
  );

  bus_good_seq #(
    .MV_W(MV_W), .RAIL2_MIN_MV(RAIL2_MIN_MV), .SS_MIN_MV(SS_MIN_MV)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .ss_mv(ss_mv), .rail2_mv(rail2_mv),
    .pwm_pulse(pwm_pulse), .inhibit(out_inhibit), .bg_d(bg_d), .bg_q(bg_q)
  );

  always_comb begin
    any_uv = |lin_uv;
    pg_d   = win_d && !any_uv && !out_inhibit && bg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= pg_d;
  end

  assign pgood    = pg_q;
  assign bus_good = bg_q;

  assert_uv_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|lin_uv) |=> !pgood);

  assert_pg_needs_bg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> bus_good);

  assert_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_inhibit |=> (!pgood && !bus_good));

  assert_win_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> win_q);
endmodule

// File: tb/sim_pwr_status_rpt.sv
module sim_pwr_status_rpt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  core_ratio_pct = 8'd100;
  logic [2:0]  lin_uv = 3'b000;
  logic [11:0] ss_mv = 12'd0;
  logic [11:0] rail2_mv = 12'd0;
  logic        pwm_pulse = 1'b0;
  logic        out_inhibit = 1'b0;
  logic        pgood, bus_good;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  bit m_win = 1'b0;
  bit m_bus = 1'b0;

  always #4 clk = ~clk;

  pwr_status_rpt u0 (
    .clk(clk), .rst_n(rst_n), .core_ratio_pct(core_ratio_pct), .lin_uv(lin_uv),
    .ss_mv(ss_mv), .rail2_mv(rail2_mv), .pwm_pulse(pwm_pulse),
    .out_inhibit(out_inhibit), .pgood(pgood), .bus_good(bus_good)
  );

  task automatic step(input int r, input logic [2:0] uv, input int ss, input int r2,
                      input bit pw, input bit inh, input string tag);
    bit pg;
    @(negedge clk);
    core_ratio_pct = 8'(r);
    lin_uv = uv;
    ss_mv = 12'(ss);
    rail2_mv = 12'(r2);
    pwm_pulse = pw;
    out_inhibit = inh;
    m_win = m_win ? (r >= 90 && r <= 110) : (r >= 92 && r <= 108);
    m_bus = !inh && (r2 >= 1080) && (ss >= 1250) && (m_bus || pw);
    pg = m_win && (uv == 3'b000) && !inh && m_bus;
    exp_q.push_back({pg, m_bus});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({pgood, bus_good} !== e) begin
        fails++;
        $display("FAIL %s: {pgood,bus_good} actual=%b expected=%b", t, {pgood, bus_good}, e);
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({pgood, bus_good} !== 2'b00) begin
      fails++;
      $display("FAIL R1: in reset actual=%b expected=00", {pgood, bus_good});
    end
    rst_n = 1'b1;
    step(100, 3'b000, 0, 1200, 1'b0, 1'b0, "R1 first cycle");
    // soft-start below threshold: pulse ignored
    step(100, 3'b000, 0, 1200, 1'b1, 1'b0, "R6 pulse ignored");
    step(100, 3'b000, 1249, 1200, 1'b1, 1'b0, "R6 ss 1249");
    // soft-start done, no pulse yet
    step(100, 3'b000, 1250, 1200, 1'b0, 1'b0, "R7 waits pulse");
    step(100, 3'b000, 1300, 1200, 1'b0, 1'b0, "R8 pgood waits bus");
    step(100, 3'b000, 1300, 1200, 1'b1, 1'b0, "R7 first pulse");
    for (int i = 0; i < 4; i++) step(100, 3'b000, 1300, 1200, 1'b0, 1'b0, "R10 holds");
    // hysteresis sweep
    step(109, 3'b000, 1300, 1200, 1'b0, 1'b0, "R3 inside keep 109");
    step(110, 3'b000, 1300, 1200, 1'b0, 1'b0, "R3 inside keep 110");
    step(111, 3'b000, 1300, 1200, 1'b0, 1'b0, "R2 above 110");
    step(109, 3'b000, 1300, 1200, 1'b0, 1'b0, "R3 outside 109");
    step(108, 3'b000, 1300, 1200, 1'b0, 1'b0, "R3 reenter 108");
    step(91, 3'b000, 1300, 1200, 1'b0, 1'b0, "R3 inside keep 91");
    step(89, 3'b000, 1300, 1200, 1'b0, 1'b0, "R2 below 90");
    step(91, 3'b000, 1300, 1200, 1'b0, 1'b0, "R3 outside 91");
    step(92, 3'b000, 1300, 1200, 1'b0, 1'b0, "R3 reenter 92");
    // under-voltage per rail
    step(100, 3'b010, 1300, 1200, 1'b0, 1'b0, "R4 uv rail");
    step(100, 3'b100, 1300, 1200, 1'b0, 1'b0, "R4 uv other rail");
    step(100, 3'b000, 1300, 1200, 1'b0, 1'b0, "R4 uv cleared");
    // rail 2 threshold
    step(100, 3'b000, 1300, 1079, 1'b0, 1'b0, "R5 rail2 1079");
    step(100, 3'b000, 1300, 1080, 1'b0, 1'b0, "R10 needs new pulse");
    step(100, 3'b000, 1300, 1080, 1'b1, 1'b0, "R7 pulse at 1080");
    // inhibit
    step(100, 3'b000, 1300, 1200, 1'b1, 1'b1, "R9 inhibit");
    step(100, 3'b000, 1300, 1200, 1'b0, 1'b0, "R10 after inhibit");
    step(100, 3'b000, 1300, 1200, 1'b1, 1'b0, "R7 pulse after inhibit");
    // soft-start falls back
    step(100, 3'b000, 1249, 1200, 1'b0, 1'b0, "R6 ss drops");
    step(100, 3'b000, 1249, 1200, 1'b1, 1'b0, "R6 pulse while ss low");
    step(100, 3'b000, 1250, 1200, 1'b0, 1'b0, "R10 ss back no pulse");
    step(100, 3'b000, 1250, 1200, 1'b1, 1'b0, "R8 rise together");
    step(100, 3'b000, 1250, 1200, 1'b0, 1'b0, "R10 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule